// File: doc/BRIEF.md
# UART Serial Receiver with Error Detection

This block turns an asynchronous serial line into characters. The line is first passed through a two-stage synchronizer. A sampling strobe at sixteen times the bit rate is then used to find the start bit, check it, and take each following bit at its centre. Frame settings are inputs shared with the matching transmitter: the data width (5 to 8 bits), whether parity is used, and which parity sense applies. Data bits arrive least significant first.

Each finished character is written to a receive queue together with its own parity, framing and break flags. The queue holds 16 entries when queueing is on and one entry when it is off. Switching the mode empties the queue. The host reads the oldest character and its flags at the output ports and pulses `pop` to discard it. The block reports an overrun when a character completes while the queue is full. It also drives an active-low ready line, which a DMA engine can watch.

The receiver rejects a start edge that does not hold low until the middle of the start bit. A line held low for a whole frame is reported as one break, not as a series of zero characters.

Top module: `uart_rx_core`

## Requirements
- R1: `word_len` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and data bits above the selected width read as zero.
- R2: With `parity_en` high, one parity bit follows the data. When `parity_even` is 1, the data bits and the parity bit must hold an even number of ones; when it is 0, an odd number. A mismatch sets `err_parity` for that character. With `parity_en` low, no parity bit is expected and `err_parity` stays 0.
- R3: A low level is taken as a start bit only if it is still low 8 sample strobes after it was first seen. Otherwise it is discarded with no character produced, and the receiver waits for the next falling level.
- R4: If the stop bit samples low on a frame that is not all zero, the character is stored with its data intact, `err_frame` set and `err_break` clear.
- R5: If the start bit, the data bits, any parity bit and the stop bit all sample low, exactly one entry is stored: data 0, `err_break` 1, `err_frame` 1, `err_parity` 0. No further character is assembled until the line has been seen high.
- R6: With `fifo_en` high, up to 16 characters are held and read back in arrival order. A `pop` with the queue empty has no effect.
- R7: With `fifo_en` low, the queue holds a single character.
- R8: A character that completes while the queue is full is discarded and sets `overrun`. `overrun` stays set until the next `pop`, which clears it.
- R9: `data_ready` is 1 and `rx_ready_n` is 0 exactly when at least one character is held. `rd_data` and the error outputs show the oldest character and read as 0 when the queue is empty.
- R10: A change of `fifo_en` empties the queue in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data width code (0..3 gives 5..8 bits) |
| parity_en | input | 1 | Expect a parity bit |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| fifo_en | input | 1 | 1 gives a 16-entry queue, 0 gives a single entry |
| pop | input | 1 | Discard the oldest character |
| rd_data | output | 8 | Oldest character |
| data_ready | output | 1 | At least one character held |
| err_parity | output | 1 | Parity error of the oldest character |
| err_frame | output | 1 | Framing error of the oldest character |
| err_break | output | 1 | Oldest entry is a break |
| overrun | output | 1 | A character was lost because the queue was full |
| rx_ready_n | output | 1 | Active-low DMA ready |

## Verification
The assertions assume that `fifo_en` holds steady through reset release. They also assume that `pop` is a plain strobe, which may be raised while the queue is empty. The bench changes the frame settings and `fifo_en` only while the line is idle and no frame is in flight. It produces each bit as exactly 16 strobes, one every fourth clock, so the sampling centre falls well inside every bit even after the synchronizer delay.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       rxd,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       parity_even,
    output logic       push,
    output rx_char_t   push_ch
);
    typedef struct packed {
        rx_state_e         st;
        logic [3:0]        tick;
        logic [2:0]        idx;
        logic [CHAR_W-1:0] sh;
        logic              par;
        logic              zero;
        logic              push;
        rx_char_t          ch;
    } fr_t;

    fr_t r_d, r_q;
    logic [2:0] last_idx;
    logic       brk;

    assign last_idx = {1'b0, word_len} + 3'd4;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        brk      = 1'b0;
        if (tick_en) begin
            case (r_q.st)
                ST_IDLE: begin
                    if (!rxd) begin
                        r_d.st   = ST_START;
                        r_d.tick = '0;
                    end
                end
                ST_START: begin
                    r_d.tick = r_q.tick + 4'd1;
                    if (r_q.tick == 4'd7) begin
                        if (!rxd) begin
                            r_d.st   = ST_DATA;
                            r_d.tick = '0;
                            r_d.idx  = '0;
                            r_d.sh   = '0;
                            r_d.par  = 1'b0;
                            r_d.zero = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    r_d.tick = r_q.tick + 4'd1;
                    if (r_q.tick == 4'd15) begin
                        r_d.sh[r_q.idx] = rxd;
                        r_d.par         = r_q.par ^ rxd;
                        r_d.zero        = r_q.zero & ~rxd;
                        r_d.idx         = r_q.idx + 3'd1;
                        if (r_q.idx == last_idx)
                            r_d.st = parity_en ? ST_PARITY : ST_STOP;
                    end
                end
                ST_PARITY: begin
                    r_d.tick = r_q.tick + 4'd1;
                    if (r_q.tick == 4'd15) begin
                        r_d.par  = r_q.par ^ rxd;
                        r_d.zero = r_q.zero & ~rxd;
                        r_d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    r_d.tick = r_q.tick + 4'd1;
                    if (r_q.tick == 4'd15) begin
                        brk          = r_q.zero & ~rxd;
                        r_d.push     = 1'b1;
                        r_d.ch.data  = brk ? '0 : r_q.sh;
                        r_d.ch.fe    = ~rxd;
                        r_d.ch.brk   = brk;
                        r_d.ch.pe    = parity_en & ~brk & (r_q.par ^ ~parity_even);
                        r_d.st       = brk ? ST_HOLD : ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    if (rxd) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign push    = r_q.push;
    assign push_ch = r_q.ch;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_en,
    input  logic                         push,
    input  rx_char_t                     push_ch,
    input  logic                         pop,
    output rx_char_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
        logic          en;
    } fq_t;

    fq_t q_d, q_q;
    rx_char_t mem_q [DEPTH];
    logic [CW-1:0] cap;
    logic full, flush, do_push, do_pop;

    always_comb begin
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        full    = (q_q.cnt >= cap);
        flush   = (fifo_en != q_q.en);
        do_pop  = pop && (q_q.cnt != '0) && !flush;
        do_push = push && !full && !flush;
        q_d     = q_q;
        q_d.en  = fifo_en;
        if (flush) begin
            q_d.wp  = '0;
            q_d.rp  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) q_d.wp = (q_q.wp == AW'(DEPTH-1)) ? '0 : q_q.wp + 1'b1;
            if (do_pop)  q_d.rp = (q_q.rp == AW'(DEPTH-1)) ? '0 : q_q.rp + 1'b1;
            q_d.cnt = q_q.cnt + CW'(do_push) - CW'(do_pop);
        end
        if (pop)         q_d.ovr = 1'b0;
        if (push && full) q_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q_q.wp] <= push_ch;
    end

    assign head    = mem_q[q_q.rp];
    assign count   = q_q.cnt;
    assign overrun = q_q.ovr;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_serial,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              parity_even,
    input  logic              fifo_en,
    input  logic              pop,
    output logic [CHAR_W-1:0] rd_data,
    output logic              data_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break,
    output logic              overrun,
    output logic              rx_ready_n
);
    localparam int CW = $clog2(DEPTH+1);

    logic          rxd;
    logic          fr_push;
    rx_char_t      fr_ch;
    rx_char_t      head;
    logic [CW-1:0] fifo_cnt;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_serial), .dout(rxd)
    );

    uart_rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .tick_en(sample_en), .rxd(rxd),
        .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
        .push(fr_push), .push_ch(fr_ch)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push(fr_push), .push_ch(fr_ch), .pop(pop),
        .head(head), .count(fifo_cnt), .overrun(overrun)
    );

    assign data_ready = (fifo_cnt != '0);
    assign rx_ready_n = ~data_ready;
    assign rd_data    = data_ready ? head.data : '0;
    assign err_parity = data_ready & head.pe;
    assign err_frame  = data_ready & head.fe;
    assign err_break  = data_ready & head.brk;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_en,
    input logic                       pop,
    input logic                       overrun,
    input logic                       data_ready,
    input logic                       fr_push,
    input rx_char_t                   fr_ch,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0 && pop && !fr_push) |=> (fifo_cnt == '0));

    p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> (fifo_cnt <= 1));

    p_overrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !pop) |=> overrun);

    p_break_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_push && fr_ch.brk) |-> (fr_ch.data == '0 && fr_ch.fe && !fr_ch.pe));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != $past(fifo_en)) |=> !data_ready);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .pop(pop), .overrun(overrun),
    .data_ready(data_ready), .fr_push(fr_push), .fr_ch(fr_ch), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b0;
    logic       fifo_en = 1'b1;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       data_ready, err_parity, err_frame, err_break, overrun, rx_ready_n;

    int checks = 0;
    int failures = 0;
    int div = 0;
    bit done = 0;

    localparam int BITCLK = 64;

    uart_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_serial(rx_serial),
        .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
        .fifo_en(fifo_en), .pop(pop), .rd_data(rd_data), .data_ready(data_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
        .overrun(overrun), .rx_ready_n(rx_ready_n)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        div = (div + 1) % 4;
        sample_en = (div == 0);
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit flip_par,
                              input bit stop_v);
        bit p;
        p = parity_even ? 1'b0 : 1'b1;
        rx_serial = 1'b0;
        wait_clks(BITCLK);
        for (int i = 0; i < nb; i++) begin
            rx_serial = d[i];
            p = p ^ d[i];
            wait_clks(BITCLK);
        end
        if (parity_en) begin
            rx_serial = p ^ flip_par;
            wait_clks(BITCLK);
        end
        rx_serial = stop_v;
        wait_clks(BITCLK);
        rx_serial = 1'b1;
        wait_clks(BITCLK);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        wait_clks(1);
        pop = 1'b0;
        wait_clks(1);
    endtask

    task automatic t_reset();
        check("R9 reset data_ready", int'(data_ready), 0);
        check("R9 reset rx_ready_n", int'(rx_ready_n), 1);
        check("R8 reset overrun", int'(overrun), 0);
        check("R9 reset rd_data", int'(rd_data), 0);
    endtask

    task automatic t_lengths();
        for (int w = 0; w < 4; w++) begin
            word_len = 2'(w);
            send_frame(8'hB5, w + 5, 0, 1);
            check("R1 length data", int'(rd_data), int'(8'hB5 & ((8'h1 << (w + 5)) - 1)));
            check("R9 rx_ready_n low", int'(rx_ready_n), 0);
            check("R1 no errors", int'({err_parity, err_frame, err_break}), 0);
            do_pop();
        end
        check("R9 empty after pops", int'(data_ready), 0);
    endtask

    task automatic t_parity();
        word_len = 2'd3;
        parity_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            parity_even = k[1];
            send_frame(8'h6B, 8, k[0], 1);
            check("R2 parity data", int'(rd_data), 8'h6B);
            check("R2 parity flag", int'(err_parity), k[0]);
            do_pop();
        end
        parity_en = 1'b0;
    endtask

    task automatic t_false_start();
        rx_serial = 1'b0;
        wait_clks(16);
        rx_serial = 1'b1;
        wait_clks(3 * BITCLK);
        check("R3 glitch ignored", int'(data_ready), 0);
        send_frame(8'h81, 8, 0, 1);
        check("R3 next frame ok", int'(rd_data), 8'h81);
        do_pop();
    endtask

    task automatic t_framing();
        send_frame(8'h3C, 8, 0, 0);
        check("R4 fe data", int'(rd_data), 8'h3C);
        check("R4 fe flag", int'(err_frame), 1);
        check("R4 no break", int'(err_break), 0);
        do_pop();
        check("R4 single entry", int'(data_ready), 0);
    endtask

    task automatic t_break();
        rx_serial = 1'b0;
        wait_clks(30 * BITCLK);
        rx_serial = 1'b1;
        wait_clks(2 * BITCLK);
        check("R5 break flag", int'(err_break), 1);
        check("R5 break fe", int'(err_frame), 1);
        check("R5 break data", int'(rd_data), 0);
        do_pop();
        check("R5 one entry", int'(data_ready), 0);
    endtask

    task automatic t_fifo_full();
        fifo_en = 1'b1;
        for (int i = 0; i < 16; i++) send_frame(8'(i * 7 + 1), 8, 0, 1);
        check("R8 no overrun at 16", int'(overrun), 0);
        send_frame(8'hEE, 8, 0, 1);
        check("R8 overrun set", int'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            check("R6 order", int'(rd_data), (i * 7 + 1) & 8'hFF);
            do_pop();
            if (i == 0) check("R8 pop clears overrun", int'(overrun), 0);
        end
        check("R8 17th discarded", int'(data_ready), 0);
        do_pop();
        check("R6 pop empty ignored", int'(data_ready), 0);
    endtask

    task automatic t_nofifo();
        fifo_en = 1'b0;
        wait_clks(4);
        send_frame(8'h11, 8, 0, 1);
        send_frame(8'h22, 8, 0, 1);
        check("R7 first kept", int'(rd_data), 8'h11);
        check("R7 overrun", int'(overrun), 1);
        do_pop();
        check("R7 single entry", int'(data_ready), 0);
    endtask

    task automatic t_flush();
        fifo_en = 1'b1;
        wait_clks(4);
        send_frame(8'h55, 8, 0, 1);
        send_frame(8'h66, 8, 0, 1);
        check("R10 loaded", int'(data_ready), 1);
        fifo_en = 1'b0;
        wait_clks(3);
        check("R10 flushed", int'(data_ready), 0);
        fifo_en = 1'b1;
        wait_clks(3);
    endtask

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        t_reset();
        t_lengths();
        t_parity();
        t_false_start();
        t_framing();
        t_break();
        t_fifo_full();
        t_nofifo();
        t_flush();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule